// File: doc/BRIEF.md
# Sandcastle Clamp and Blanking Generator

This block drives the two-level sandcastle signal that a display controller sends to its video stage. The output is a two-bit level code. The upper level is a short clamp pulse tied to each horizontal sync. The lower level is vertical blanking. The analog levels themselves are produced elsewhere. The inputs are:

- a normalized, active-high horizontal sync;
- a one-cycle vertical sync trigger;
- a one-cycle strobe that marks the start of the vertical scan;
- a set of fault and status flags;
- three control bits from the register file.

The clamp pulse is fired by a one-shot counter. A control bit decides whether the rising or the falling edge of horizontal sync starts it. Its length does not depend on how long sync stays high.

Vertical blanking starts with the vertical trigger. It ends only when two things have happened: the selected minimum width has run out, and the scan-start strobe has arrived. A second control bit picks the minimum width, either 260 µs or 350 µs, and the block converts that time into clock cycles from a clock-frequency parameter.

Several conditions force blanking on for as long as they last. They fall into two groups:

- Protection group: soft start in progress, missing flyback, X-ray trip, supply undervoltage. This group can never be masked.
- Unlock group: oscillator unlocked during frequency search, horizontal sync absent. A mask bit can remove this group.

Top module: `sandcastle_gen`

## Requirements
- R1: After reset, and with every input low, the level code is 2'b00 (video).
- R2: With `clamp_lead`=0, a falling edge of `hsync` starts the clamp. A rising edge does not. The level code shows 2'b10 from the clock edge that first samples the new `hsync` value.
- R3: With `clamp_lead`=1, a rising edge of `hsync` starts the clamp. A falling edge does not.
- R4: The clamp lasts exactly CLAMP_CYC cycles, whether the sync pulse is shorter or longer than that.
- R5: A sync edge of the selected kind that arrives while the clamp is running is ignored. The pulse still ends CLAMP_CYC cycles after it started.
- R6: A `vsync_trig` pulse raises blanking (level code 2'b01 when no clamp is active) at the clock edge that samples it.
- R7: Blanking lasts at least floor(260·CLK_KHZ/1000) cycles when `vblk_long`=0 and floor(350·CLK_KHZ/1000) cycles when `vblk_long`=1. The count starts with the first blanked cycle.
- R8: Once the minimum width has passed, blanking holds until a `scan_start` strobe and drops at the edge that samples it. A `scan_start` received outside blanking has no effect.
- R9: While `softstart_busy`, `flyback_missing`, `xray_trip` or `supply_low` is high, blanking is forced one cycle later, whatever the value of `unlock_mask`.
- R10: While `pll_search_unlock` or `hsync_absent` is high, blanking is forced one cycle later, but only when `unlock_mask`=0.
- R11: Bit 1 of the level code is the clamp and bit 0 is blanking. When both are active the code is 2'b10, and 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | Normalized horizontal sync, active high |
| vsync_trig | input | 1 | One-cycle vertical sync trigger |
| scan_start | input | 1 | One-cycle strobe at the start of vertical scan |
| clamp_lead | input | 1 | 1: clamp on rising sync edge; 0: on falling edge |
| vblk_long | input | 1 | 1: 350 µs minimum blanking; 0: 260 µs |
| unlock_mask | input | 1 | 1: suppress unlock-group forced blanking |
| softstart_busy | input | 1 | Soft start in progress |
| hsync_absent | input | 1 | No horizontal sync detected |
| pll_search_unlock | input | 1 | Oscillator unlocked while frequency search runs |
| flyback_missing | input | 1 | No flyback pulses |
| xray_trip | input | 1 | X-ray protection tripped |
| supply_low | input | 1 | Supply undervoltage flagged |
| level | output | 2 | Sandcastle code: 00 video, 01 blank, 10 clamp |

## Verification
The clamp one-shot and vertical blanking can be active in the same cycle. The bench forces this by raising `hsync` (leading-edge mode) in the same cycle as `vsync_trig`. It then expects the code 2'b10 for exactly CLAMP_CYC cycles, followed at once by 2'b01 until the scan strobe ends blanking. A clamp that was lost, merged with blanking, or shown as 2'b11 is each reported as a failed check. A retriggered sync edge during a running pulse is judged the same way, by the cycle in which the code falls back.

// File: rtl/sandcastle_pkg.sv
package sandcastle_pkg;

  typedef enum logic [1:0] {
    LVL_VIDEO = 2'b00,
    LVL_BLANK = 2'b01,
    LVL_CLAMP = 2'b10
  } sc_level_e;

  localparam int unsigned VB_SHORT_US = 260;
  localparam int unsigned VB_LONG_US  = 350;

  // microseconds to whole clock cycles for a clock given in kHz
  function automatic int unsigned us_to_cycles(input int unsigned us,
                                               input int unsigned khz);
    return (us * khz) / 1000;
  endfunction

  // at least one cycle so the timer always has work to do
  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // clamp wins over blanking
  function automatic sc_level_e encode_level(input logic clamp_on,
                                             input logic blank_on);
    if (clamp_on) return LVL_CLAMP;
    if (blank_on) return LVL_BLANK;
    return LVL_VIDEO;
  endfunction

endpackage

// File: rtl/sc_clamp_oneshot.sv
module sc_clamp_oneshot #(
  parameter int unsigned CLAMP_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync,
  input  logic lead_sel,
  output logic fire,
  output logic active
);
  localparam int unsigned CW = $clog2(CLAMP_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(CLAMP_CYC);

  logic          hs_q;
  logic [CW-1:0] cnt;
  logic          edge_rise;
  logic          edge_fall;

  assign edge_rise = hsync & ~hs_q;
  assign edge_fall = ~hsync & hs_q;
  assign fire      = lead_sel ? edge_rise : edge_fall;
  assign active    = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      cnt  <= '0;
    end else begin
      hs_q <= hsync;
      if (fire && !active) cnt <= LOAD;
      else if (active)     cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sc_vblank_timer.sv
module sc_vblank_timer
  import sandcastle_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync_trig,
  input  logic scan_start,
  input  logic long_sel,
  output logic active
);
  localparam int unsigned W_SHORT = at_least_one(us_to_cycles(VB_SHORT_US, CLK_KHZ));
  localparam int unsigned W_LONG  = at_least_one(us_to_cycles(VB_LONG_US, CLK_KHZ));
  localparam int unsigned W_MAX   = (W_LONG > W_SHORT) ? W_LONG : W_SHORT;
  localparam int unsigned TW      = $clog2(W_MAX + 1);
  localparam logic [TW-1:0] LOAD_S = TW'(W_SHORT);
  localparam logic [TW-1:0] LOAD_L = TW'(W_LONG);
  localparam logic [TW-1:0] ONE    = TW'(1);

  logic [TW-1:0] tmr;
  logic          seen_scan;
  logic          vb;
  logic          min_done;

  assign min_done = (tmr <= ONE);
  assign active   = vb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vb        <= 1'b0;
      tmr       <= '0;
      seen_scan <= 1'b0;
    end else if (vsync_trig) begin
      vb        <= 1'b1;
      tmr       <= long_sel ? LOAD_L : LOAD_S;
      seen_scan <= 1'b0;
    end else if (vb) begin
      if (tmr != '0) tmr <= tmr - 1'b1;
      seen_scan <= seen_scan | scan_start;
      if (min_done && (seen_scan || scan_start)) vb <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_force_blank.sv
module sc_force_blank (
  input  logic clk,
  input  logic rst_n,
  input  logic unlock_mask,
  input  logic softstart_busy,
  input  logic hsync_absent,
  input  logic pll_search_unlock,
  input  logic flyback_missing,
  input  logic xray_trip,
  input  logic supply_low,
  output logic force_on
);
  logic protect_raw;
  logic unlock_raw;

  assign protect_raw = softstart_busy | flyback_missing | xray_trip | supply_low;
  assign unlock_raw  = (pll_search_unlock | hsync_absent) & ~unlock_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_on <= 1'b0;
    else        force_on <= protect_raw | unlock_raw;
  end
endmodule

// File: rtl/sandcastle_gen.sv
module sandcastle_gen
  import sandcastle_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 20000,
  parameter int unsigned CLAMP_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync,
  input  logic       vsync_trig,
  input  logic       scan_start,
  input  logic       clamp_lead,
  input  logic       vblk_long,
  input  logic       unlock_mask,
  input  logic       softstart_busy,
  input  logic       hsync_absent,
  input  logic       pll_search_unlock,
  input  logic       flyback_missing,
  input  logic       xray_trip,
  input  logic       supply_low,
  output logic [1:0] level
);
  logic clamp_fire;
  logic clamp_on;
  logic vb_on;
  logic force_on;
  sc_level_e lvl;

  sc_clamp_oneshot #(.CLAMP_CYC(CLAMP_CYC)) u_clamp (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .lead_sel(clamp_lead),
    .fire(clamp_fire), .active(clamp_on)
  );

  sc_vblank_timer #(.CLK_KHZ(CLK_KHZ)) u_vblank (
    .clk(clk), .rst_n(rst_n), .vsync_trig(vsync_trig),
    .scan_start(scan_start), .long_sel(vblk_long), .active(vb_on)
  );

  sc_force_blank u_force (
    .clk(clk), .rst_n(rst_n), .unlock_mask(unlock_mask),
    .softstart_busy(softstart_busy), .hsync_absent(hsync_absent),
    .pll_search_unlock(pll_search_unlock), .flyback_missing(flyback_missing),
    .xray_trip(xray_trip), .supply_low(supply_low), .force_on(force_on)
  );

  assign lvl   = encode_level(clamp_on, vb_on | force_on);
  assign level = lvl;
endmodule

// File: rtl/sandcastle_chk.sv
module sandcastle_chk #(
  parameter int unsigned CLAMP_CYC = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       vsync_trig,
  input logic       unlock_mask,
  input logic       softstart_busy,
  input logic       hsync_absent,
  input logic       pll_search_unlock,
  input logic       flyback_missing,
  input logic       xray_trip,
  input logic       supply_low,
  input logic       clamp_fire,
  input logic       clamp_on,
  input logic [1:0] level
);
  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (clamp_on) run_len <= run_len + 1;
    else               run_len <= '0;
  end

  // R11: clamp and blank never share the code
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    level != 2'b11);

  // R4: an accepted edge starts the pulse
  a_r4_fire_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_fire && !clamp_on) |=> (level == 2'b10));

  // R5: pulse never outlives its width
  a_r5_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_on |-> (run_len < CLAMP_CYC));

  // R6: vertical trigger blanks at once
  a_r6_vsync_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_trig |=> (level != 2'b00));

  // R9: protection cannot be masked
  a_r9_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (softstart_busy || flyback_missing || xray_trip || supply_low) |=> (level != 2'b00));

  // R10: unmasked unlock forces blanking
  a_r10_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    ((pll_search_unlock || hsync_absent) && !unlock_mask) |=> (level != 2'b00));
endmodule

bind sandcastle_gen sandcastle_chk #(.CLAMP_CYC(CLAMP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync_trig(vsync_trig), .unlock_mask(unlock_mask),
  .softstart_busy(softstart_busy), .hsync_absent(hsync_absent),
  .pll_search_unlock(pll_search_unlock), .flyback_missing(flyback_missing),
  .xray_trip(xray_trip), .supply_low(supply_low), .clamp_fire(clamp_fire),
  .clamp_on(clamp_on), .level(level)
);

// File: tb/sandcastle_gen_test.sv
module sandcastle_gen_test;
  localparam int PER   = 10;
  localparam int KHZ   = 100;
  localparam int CCYC  = 4;
  localparam int WS    = (260 * KHZ) / 1000;
  localparam int WL    = (350 * KHZ) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 0, vsync_trig = 0, scan_start = 0, clamp_lead = 0, vblk_long = 0;
  logic unlock_mask = 0, softstart_busy = 0, hsync_absent = 0, pll_search_unlock = 0;
  logic flyback_missing = 0, xray_trip = 0, supply_low = 0;
  logic [1:0] level;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  sandcastle_gen #(.CLK_KHZ(KHZ), .CLAMP_CYC(CCYC)) uut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync_trig(vsync_trig),
    .scan_start(scan_start), .clamp_lead(clamp_lead), .vblk_long(vblk_long),
    .unlock_mask(unlock_mask), .softstart_busy(softstart_busy),
    .hsync_absent(hsync_absent), .pll_search_unlock(pll_search_unlock),
    .flyback_missing(flyback_missing), .xray_trip(xray_trip),
    .supply_low(supply_low), .level(level)
  );

  // {softstart, absent, unlock, flyback, xray, supply, mask, expected[1:0]}
  localparam logic [8:0] FTAB [10] = '{
    9'b0000000_00, 9'b1000000_01, 9'b0100000_01, 9'b0100001_00,
    9'b0010000_01, 9'b0010001_00, 9'b0001001_01, 9'b0000101_01,
    9'b0000010_01, 9'b0010011_01
  };

  task automatic tick();
    @(posedge clk);
    #(PER/4);
  endtask

  task automatic chk(input string req, input logic [1:0] exp);
    checks++;
    if (level !== exp) begin
      errors++;
      $display("FAIL %s: level=%b expected=%b at %0t", req, level, exp, $time);
    end
  endtask

  initial begin
    #(PER * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 reset state", 2'b00);

    // forced blanking table: R9 protection, R10 unlock with mask
    foreach (FTAB[i]) begin
      {softstart_busy, hsync_absent, pll_search_unlock, flyback_missing,
       xray_trip, supply_low, unlock_mask} = FTAB[i][8:2];
      tick();
      chk("R9 or R10 forced blanking row", FTAB[i][1:0]);
      {softstart_busy, hsync_absent, pll_search_unlock, flyback_missing,
       xray_trip, supply_low, unlock_mask} = '0;
      tick();
      chk("R9 or R10 release", 2'b00);
    end

    // R2: trailing edge mode
    clamp_lead = 0; hsync = 1;
    tick(); chk("R2 rising edge ignored", 2'b00);
    tick(); tick(); chk("R2 still idle during sync", 2'b00);
    hsync = 0;
    tick(); chk("R2 trailing edge fires", 2'b10);
    for (int i = 2; i <= CCYC; i++) begin tick(); chk("R4 trailing width", 2'b10); end
    tick(); chk("R4 trailing pulse ends", 2'b00);

    // R3 with short sync
    clamp_lead = 1; hsync = 1;
    tick(); chk("R3 leading edge fires", 2'b10);
    hsync = 0;
    for (int i = 2; i <= CCYC; i++) begin tick(); chk("R4 short sync width", 2'b10); end
    tick(); chk("R4 short sync end", 2'b00);
    tick(); chk("R3 falling edge ignored", 2'b00);

    // R4 long sync
    hsync = 1;
    tick(); chk("R4 long sync starts", 2'b10);
    for (int i = 2; i <= CCYC; i++) tick();
    tick(); chk("R4 ends while sync high", 2'b00);
    tick(); tick(); chk("R4 stays idle", 2'b00);
    hsync = 0; tick();

    // R5 retrigger ignored
    hsync = 1; tick(); chk("R5 first pulse", 2'b10);
    hsync = 0; tick();
    hsync = 1; tick(); chk("R5 running", 2'b10);
    for (int i = 4; i <= CCYC; i++) tick();
    tick(); chk("R5 no retrigger", 2'b00);
    hsync = 0; tick();

    // R6/R7 short width, early scan strobe
    vblk_long = 0; vsync_trig = 1;
    tick(); chk("R6 blank starts", 2'b01);
    vsync_trig = 0; scan_start = 1;
    tick(); scan_start = 0;
    for (int i = 3; i <= WS; i++) tick();
    chk("R7 short minimum held", 2'b01);
    tick(); chk("R7 short minimum ends", 2'b00);

    // R7/R8 long width, late scan strobe
    vblk_long = 1; vsync_trig = 1;
    tick(); vsync_trig = 0;
    for (int i = 2; i <= WL; i++) tick();
    chk("R7 long minimum held", 2'b01);
    for (int i = 0; i < 5; i++) tick();
    chk("R8 waits for scan start", 2'b01);
    scan_start = 1; tick(); scan_start = 0;
    chk("R8 scan start ends blank", 2'b00);

    // R8 stray strobe outside blanking
    scan_start = 1; tick(); scan_start = 0;
    chk("R8 idle strobe no effect", 2'b00);
    vblk_long = 0; vsync_trig = 1; tick(); vsync_trig = 0;
    for (int i = 2; i <= WS + 3; i++) tick();
    chk("R8 stray strobe not remembered", 2'b01);
    scan_start = 1; tick(); scan_start = 0;
    chk("R8 release", 2'b00);

    // R11 clamp and blank in the same cycle
    clamp_lead = 1; hsync = 1; vsync_trig = 1;
    tick(); vsync_trig = 0;
    chk("R11 clamp over blank", 2'b10);
    for (int i = 2; i <= CCYC; i++) tick();
    chk("R11 clamp last cycle", 2'b10);
    tick(); chk("R11 blank underneath", 2'b01);
    hsync = 0;
    for (int i = CCYC + 2; i <= WS; i++) tick();
    scan_start = 1; tick(); scan_start = 0;
    chk("R11 back to video", 2'b00);

    // R11 clamp during protection blanking
    xray_trip = 1; tick(); chk("R9 xray blank", 2'b01);
    hsync = 1; tick(); chk("R11 clamp over forced blank", 2'b10);
    hsync = 0; xray_trip = 0;
    for (int i = 0; i < CCYC + 2; i++) tick();
    chk("R1 quiet end", 2'b00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule